// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-byte CPU memory requests into bus cycles on an external bus. The bus has separate active-low address and data strobes, a read/write line, a dedicated high address byte, and a low byte lane that carries the address first and the data after it. For each request the block decides from the address whether the target is on-chip or external. Addresses below a parameterised limit are on-chip. Every cycle lasts four clock phases and starts with one address strobe pulse. On-chip cycles leave the data strobe high, keep read/write high and leave both address lanes undriven.

An external cycle has four phases. In the first, the low address byte is on the shared lane and the address strobe is low. In the second, the address strobe rises and the lane switches to write data, or to high impedance for a read. In the third, the data strobe is low. In the fourth, the data strobe is high again, read data captured on that rising edge is on `rdata`, and `done` is high. The number of driven high address lines follows the external address width parameter, which is 11 or 16 lines.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `as_n`, `ds_n` and `rw_n` are 1, `ad_oe` and `ahi_oe` are 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only when `req_ready` is 1. The first phase follows in the next cycle. A `req_valid` raised while a cycle is running starts no extra cycle.
- R3: `as_n` is 0 for exactly one cycle per access, in phase 1, for both on-chip and external accesses.
- R4: On an external write, the lane drives `addr[7:0]` in phase 1 and the write data in phases 2 to 4, with `ad_oe` at 1 throughout.
- R5: On an external read, `ad_oe` is 0 in phases 2 to 4. `rdata` takes the `ad_in` value present at the end of phase 3 and shows it from phase 4 on. On-chip reads leave `rdata` unchanged.
- R6: `ds_n` is 0 only in phase 3 of an external access and stays 1 for the whole of an on-chip access.
- R7: `rw_n` is 0 in phases 1 to 4 of an external write and 1 at all other times.
- R8: An access is on-chip when its address is below `INT_LIMIT` (default 16'h1000) and external otherwise. On-chip accesses drive neither the low lane nor the high lane.
- R9: During phases 1 to 4 of an external access, `ahi_out` bits 0 to `EXT_LINES`-9 carry `addr[15:8]` with their `ahi_oe` bits at 1. The other bits are undriven. With the default of 16 lines, all eight bits are driven.
- R10: `done` is high for exactly the single cycle of phase 4, and `req_ready` returns to 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read from the external bus |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 0 for external writes, otherwise 1 |
| ad_out | output | 8 | Shared low lane output, address then data |
| ad_oe | output | 1 | Output enable of the shared lane |
| ad_in | input | 8 | Shared low lane input |
| ahi_out | output | 8 | High address byte |
| ahi_oe | output | 8 | Per-bit output enable of the high address byte |

## Verification
A request driven before rising edge k is taken at edge k. Phases 1, 2, 3 and 4 then occupy the cycles after edges k, k+1, k+2 and k+3, and the block is idle again after edge k+4. The read byte must be on `ad_in` before edge k+3 and appears on `rdata` in phase 4, together with `done`. The bench raises the request on a falling edge and then samples every strobe, lane and enable at each following falling edge, one sample per phase plus one in the idle cycle after the access. Each sample is compared against the value that the requirement fixes for that phase.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    parameter int ADDR_W = 16;
    parameter int BYTE_W = 8;
    localparam int HI_W  = ADDR_W - BYTE_W;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TURN = 3'd2,
        PH_STRB = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   wdata;
        logic                wr;
        logic                ext;
    } cyc_s;

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INT_LIMIT = 16'h1000,
    parameter int                EXT_LINES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ext,
    output logic [HI_W-1:0]   hi_mask
);

    localparam int HI_USED = EXT_LINES - BYTE_W;

    assign is_ext = (addr >= INT_LIMIT);

    for (genvar i = 0; i < HI_W; i++) begin : g_hi_mask
        assign hi_mask[i] = (i < HI_USED) ? 1'b1 : 1'b0;
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              is_ext,
    output cyc_s              cyc,
    output logic              idle
);

    cyc_s cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        unique case (cyc_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    cyc_d.phase = PH_ADDR;
                    cyc_d.addr  = req_addr;
                    cyc_d.wdata = req_wdata;
                    cyc_d.wr    = req_write;
                    cyc_d.ext   = is_ext;
                end
            end
            PH_ADDR: cyc_d.phase = PH_TURN;
            PH_TURN: cyc_d.phase = PH_STRB;
            PH_STRB: cyc_d.phase = PH_DONE;
            PH_DONE: cyc_d.phase = PH_IDLE;
            default: cyc_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '{phase: PH_IDLE, addr: '0, wdata: '0, wr: 1'b0, ext: 1'b0};
        end else begin
            cyc_q <= cyc_d;
        end
    end

    assign cyc  = cyc_q;
    assign idle = (cyc_q.phase == PH_IDLE);

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_s              cyc,
    input  logic [HI_W-1:0]   hi_mask,
    input  logic [BYTE_W-1:0] ad_in,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   ahi_out,
    output logic [HI_W-1:0]   ahi_oe,
    output logic              done,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] rdata_d, rdata_q;
    logic busy, data_ph;

    always_comb begin
        busy    = (cyc.phase != PH_IDLE);
        data_ph = (cyc.phase == PH_TURN) || (cyc.phase == PH_STRB) ||
                  (cyc.phase == PH_DONE);
        as_n    = (cyc.phase != PH_ADDR);
        ds_n    = !((cyc.phase == PH_STRB) && cyc.ext);
        rw_n    = !(busy && cyc.ext && cyc.wr);
        ad_oe   = cyc.ext && ((cyc.phase == PH_ADDR) || (data_ph && cyc.wr));
        if (!ad_oe)
            ad_out = '0;
        else if (cyc.phase == PH_ADDR)
            ad_out = cyc.addr[BYTE_W-1:0];
        else
            ad_out = cyc.wdata;
        ahi_oe  = (busy && cyc.ext) ? hi_mask : '0;
        ahi_out = cyc.addr[ADDR_W-1:BYTE_W] & ahi_oe;
        done    = (cyc.phase == PH_DONE);
        rdata_d = rdata_q;
        if ((cyc.phase == PH_STRB) && cyc.ext && !cyc.wr)
            rdata_d = ad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter logic [15:0] INT_LIMIT = 16'h1000,
    parameter int          EXT_LINES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        done,
    output logic [7:0]  rdata,
    output logic        as_n,
    output logic        ds_n,
    output logic        rw_n,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic [7:0]  ahi_out,
    output logic [7:0]  ahi_oe
);

    logic            is_ext;
    logic [HI_W-1:0] hi_mask;
    cyc_s            cyc;

    xbus_decode #(
        .INT_LIMIT (INT_LIMIT),
        .EXT_LINES (EXT_LINES)
    ) decode_i (
        .addr    (req_addr),
        .is_ext  (is_ext),
        .hi_mask (hi_mask)
    );

    xbus_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .is_ext    (is_ext),
        .cyc       (cyc),
        .idle      (req_ready)
    );

    xbus_lane lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (cyc),
        .hi_mask (hi_mask),
        .ad_in   (ad_in),
        .as_n    (as_n),
        .ds_n    (ds_n),
        .rw_n    (rw_n),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ahi_out (ahi_out),
        .ahi_oe  (ahi_oe),
        .done    (done),
        .rdata   (rdata)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       as_n,
    input logic       ds_n,
    input logic       rw_n,
    input logic       ad_oe,
    input logic [7:0] ahi_oe
);

    // R3
    as_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |=> as_n);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !as_n);

    // R6
    ds_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> ($past(as_n, 2) == 1'b0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw_n) |-> !ad_oe);

    // R7
    rw_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> (ahi_oe != 8'h00));

endmodule

bind xbus_ctrl xbus_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .rw_n      (rw_n),
    .ad_oe     (ad_oe),
    .ahi_oe    (ahi_oe)
);

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, done, as_n, ds_n, rw_n, ad_oe;
    logic [7:0] rdata, ad_out, ahi_out, ahi_oe;
    logic [7:0] ad_in = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_rd = 8'h00;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ahi_out(ahi_out),
        .ahi_oe(ahi_oe)
    );

    // {write, addr, wdata, read byte on lane}
    localparam logic [32:0] VECS [0:7] = '{
        {1'b1, 16'hA35C, 8'h3C, 8'h00},
        {1'b0, 16'h1000, 8'h00, 8'h96},
        {1'b1, 16'h0FFF, 8'h55, 8'h00},
        {1'b0, 16'h0000, 8'h00, 8'hAA},
        {1'b0, 16'hFFFF, 8'h00, 8'h00},
        {1'b1, 16'h1234, 8'hFF, 8'h00},
        {1'b0, 16'h8001, 8'h00, 8'h5A},
        {1'b1, 16'h0800, 8'h01, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic run_vec(input logic wr, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rin);
        logic ext;
        ext = (addr >= 16'h1000);
        @(negedge clk);
        check("R2 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);                       // phase 1
        req_valid = 1'b0;
        check("R3 as_n phase1", 32'(as_n), 0);
        check("R6 ds_n phase1", 32'(ds_n), 1);
        check("R7 rw_n phase1", 32'(rw_n), 32'(!(ext && wr)));
        check("R8 ad_oe phase1", 32'(ad_oe), 32'(ext));
        if (ext) check("R4 addr low on lane", 32'(ad_out), 32'(addr[7:0]));
        check("R9 ahi_oe", 32'(ahi_oe), ext ? 32'hFF : 32'h0);
        if (ext) check("R9 ahi_out", 32'(ahi_out), 32'(addr[15:8]));
        @(negedge clk);                       // phase 2
        check("R3 as_n phase2", 32'(as_n), 1);
        check("R6 ds_n phase2", 32'(ds_n), 1);
        check("R4 R5 ad_oe phase2", 32'(ad_oe), 32'(ext && wr));
        if (ext && wr) check("R4 wdata phase2", 32'(ad_out), 32'(wd));
        ad_in = rin;
        @(negedge clk);                       // phase 3
        check("R6 ds_n phase3", 32'(ds_n), 32'(!ext));
        check("R7 rw_n phase3", 32'(rw_n), 32'(!(ext && wr)));
        check("R4 R5 ad_oe phase3", 32'(ad_oe), 32'(ext && wr));
        check("R9 ahi_oe phase3", 32'(ahi_oe), ext ? 32'hFF : 32'h0);
        @(negedge clk);                       // phase 4
        ad_in = 8'h00;
        if (ext && !wr) exp_rd = rin;
        check("R6 ds_n phase4", 32'(ds_n), 1);
        check("R10 done phase4", 32'(done), 1);
        check("R10 ready phase4", 32'(req_ready), 0);
        check("R5 rdata", 32'(rdata), 32'(exp_rd));
        if (ext && wr) check("R4 wdata phase4", 32'(ad_out), 32'(wd));
        @(negedge clk);                       // idle
        check("R10 done cleared", 32'(done), 0);
        check("R10 ready again", 32'(req_ready), 1);
        check("R3 as_n idle", 32'(as_n), 1);
        check("R7 rw_n idle", 32'(rw_n), 1);
        check("R8 lanes released", 32'({ad_oe, ahi_oe}), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin : main
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        check("R1 as_n in reset", 32'(as_n), 1);
        check("R1 ds_n in reset", 32'(ds_n), 1);
        check("R1 rw_n in reset", 32'(rw_n), 1);
        check("R1 oe in reset", 32'({ad_oe, ahi_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 1);
        check("R1 done after reset", 32'(done), 0);

        for (int i = 0; i < 8; i++) begin
            run_vec(VECS[i][32], VECS[i][31:16], VECS[i][15:8], VECS[i][7:0]);
        end

        // R2: request raised mid-cycle is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4000;
        @(negedge clk);                       // phase 1
        req_addr = 16'h7700; req_write = 1'b1; req_wdata = 8'hEE;
        @(negedge clk);                       // phase 2, request still high
        check("R2 no write from busy request", 32'(ad_oe), 0);
        @(negedge clk);                       // phase 3
        req_valid = 1'b0;
        @(negedge clk);                       // phase 4
        check("R10 done in R2 test", 32'(done), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2 no extra strobe", 32'(as_n), 1);
            check("R2 idle held", 32'(req_ready), 1);
        end

        // R1: reset asserted in the middle of an external write
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2222; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);                       // phase 3, ds_n low
        rst_n = 1'b0;
        #1;
        check("R1 ds_n released by reset", 32'(ds_n), 1);
        check("R1 rw_n released by reset", 32'(rw_n), 1);
        check("R1 lanes released by reset", 32'({ad_oe, ahi_oe}), 0);
        check("R1 rdata cleared", 32'(rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_rd = 8'h00;
        @(negedge clk);
        check("R1 ready after mid reset", 32'(req_ready), 1);
        run_vec(1'b0, 16'h1001, 8'h00, 8'hC3);

        finish_sim();
    end

endmodule